// File: doc/BRIEF.md
# Multi-Lane I2S Audio Transmitter

This block turns parallel multichannel PCM frames into serial audio on up to four I2S data lanes. Every lane shares one master clock, one bit clock and one left/right clock, all divided down from the system clock. A frame holds eight 32-bit channel words; lane `l` sends channel `2l` in the left half and channel `2l+1` in the right half, so an 8-channel frame occupies all four lanes at once.

Software sets the number of active channels (2, 4, 6 or 8) and the sample word length (16, 24 or 32 bits). Both settings are captured together with each frame, so a change only takes effect on a frame boundary. Frames come in over a valid/ready interface that is offered once per frame, just before the left half starts. If no frame is waiting then, the block sends a silent frame and raises a sticky underrun flag.

With the default division (MCLK at half the system clock, 8 MCLK periods per bit clock, 64 bit clocks per frame), MCLK runs at 512 times the frame rate. The integer dividers are parameters, so the same block covers the usual 44.1/48 kHz rate families and their multiples when it is fed a suitable system clock.

Top module: `i2s_multilane_tx`

## Requirements
- R1: Lane `l` transmits channel `2l` in its left half-frame and channel `2l+1` in its right half-frame; channel `c` is taken from `frame_data_i[32c+31:32c]`.
- R2: `ch_cfg_i` values 0, 1, 2 and 3 select 2, 4, 6 and 8 channels and enable lanes 0..`ch_cfg_i`; every slot bit of a lane above `ch_cfg_i` is sent as zero.
- R3: `wlen_i` value 0 selects 16 bits, 1 selects 24 bits, 2 or 3 select 32 bits; the sample is the upper word-length bits of each channel word and the rest of the 32-bit slot is sent as zero.
- R4: `lrck_o` and `sd_o` change only in the cycle where `bclk_o` falls, so a receiver samples them on the rising edge.
- R5: A frame is 64 bit clocks: `lrck_o` low for 32 (left), then high for 32 (right); each slot is sent MSB first, starting one bit clock after the `lrck_o` transition.
- R6: `mclk_o` toggles every `MCLK_HALF` system cycles and one `bclk_o` period lasts `BCLK_RATIO` MCLK periods (16 system cycles by default).
- R7: `frame_ready_o` is high for exactly one system cycle per frame, the cycle before the `bclk_o` fall that starts a left half; data, `ch_cfg_i` and `wlen_i` are captured in that cycle when `frame_valid_i` is high.
- R8: If `frame_valid_i` is low while `frame_ready_o` is high, the whole following frame is sent as zeros on every lane and `underrun_o` rises; it stays high until reset.
- R9: During reset `bclk_o`, `mclk_o`, `sd_o`, `frame_ready_o` and `underrun_o` are 0 and `lrck_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | A frame is offered |
| frame_ready_o | output | 1 | Frame accepted this cycle if valid |
| frame_data_i | input | 256 | Eight 32-bit channel words, channel 0 in the low bits |
| ch_cfg_i | input | 2 | Active channel count select (0..3 for 2..8 channels) |
| wlen_i | input | 2 | Word length select |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Left/right clock, low for left |
| sd_o | output | 4 | Serial data, one bit per lane |
| underrun_o | output | 1 | Sticky flag: a frame slot found no data |

## Verification
The bench decodes every lane as an I2S receiver would, so a design that sends data in the same bit clock as the LRCK edge rather than one clock later, or that puts the LSB first, shows a stream off by one bit or reversed. Frames with 16- and 24-bit words whose low bits are all ones catch a design that leaves padding bits unmasked. Channel counts of 2, 4 and 6 catch a lane that keeps sending stale or live data while disabled, and a missed frame slot between two real frames catches a design that repeats the last frame or fails to hold the underrun flag.

// File: rtl/i2s_mltx_pkg.sv
package i2s_mltx_pkg;

  localparam int unsigned SLOT_W = 32;

  typedef enum logic [1:0] {
    WL_16  = 2'd0,
    WL_24  = 2'd1,
    WL_32  = 2'd2,
    WL_32B = 2'd3
  } wlen_e;

  // Ones over the upper word-length bits of a slot.
  function automatic logic [SLOT_W-1:0] slot_mask(wlen_e wl);
    int unsigned keep;
    case (wl)
      WL_16:   keep = 16;
      WL_24:   keep = 24;
      default: keep = SLOT_W;
    endcase
    return ~((SLOT_W'(1) << (SLOT_W - keep)) - SLOT_W'(1));
  endfunction

endpackage

// File: rtl/i2s_mltx_clkgen.sv
module i2s_mltx_clkgen #(
  parameter int unsigned MCLK_HALF  = 1,
  parameter int unsigned BCLK_RATIO = 8,
  parameter int unsigned SLOT_W     = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mclk_o,
  output logic bclk_o,
  output logic lrck_o,
  output logic tick_o,
  output logic frame_start_o
);
  localparam int unsigned BCLK_PERIOD = 2 * MCLK_HALF * BCLK_RATIO;
  localparam int unsigned BCLK_HALF   = BCLK_PERIOD / 2;
  localparam int unsigned FRAME_BITS  = 2 * SLOT_W;
  localparam int unsigned DIV_W       = $clog2(BCLK_PERIOD);
  localparam int unsigned POS_W       = $clog2(FRAME_BITS);
  localparam int unsigned MC_W        = $clog2(MCLK_HALF + 1);

  logic [MC_W-1:0]  mc_cnt;
  logic             mclk_q;
  logic [DIV_W-1:0] div_cnt;
  logic             bclk_q;
  logic             lrck_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nxt;
  logic             tick;

  assign tick    = (div_cnt == DIV_W'(BCLK_PERIOD - 1));
  assign pos_nxt = (pos_q == POS_W'(FRAME_BITS - 1)) ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc_cnt  <= '0;
      mclk_q  <= 1'b0;
      div_cnt <= '0;
      bclk_q  <= 1'b0;
      lrck_q  <= 1'b1;
      pos_q   <= POS_W'(FRAME_BITS - 1);
    end else begin
      if (mc_cnt == MC_W'(MCLK_HALF - 1)) begin
        mc_cnt <= '0;
        mclk_q <= ~mclk_q;
      end else begin
        mc_cnt <= mc_cnt + 1'b1;
      end
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (div_cnt == DIV_W'(BCLK_HALF - 1)) bclk_q <= 1'b1;
      if (tick) begin
        bclk_q <= 1'b0;
        pos_q  <= pos_nxt;
        lrck_q <= (pos_nxt >= POS_W'(SLOT_W));
      end
    end
  end

  assign mclk_o        = mclk_q;
  assign bclk_o        = bclk_q;
  assign lrck_o        = lrck_q;
  assign tick_o        = tick;
  assign frame_start_o = tick && (pos_q == POS_W'(FRAME_BITS - 1));

endmodule

// File: rtl/i2s_mltx_pack.sv
module i2s_mltx_pack
  import i2s_mltx_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned CFG_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic [2*NUM_LANES*SLOT_W-1:0]         frame_data_i,
  input  logic [CFG_W-1:0]                      ch_cfg_i,
  input  logic [1:0]                            wlen_i,
  output logic [NUM_LANES-1:0][2*SLOT_W-1:0]    lane_data_o
);
  logic [SLOT_W-1:0] mask;
  assign mask = slot_mask(wlen_e'(wlen_i));

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic en;
    assign en = (CFG_W'(l) <= ch_cfg_i);
    assign lane_data_o[l] = en ?
      {frame_data_i[(2*l)*SLOT_W +: SLOT_W] & mask,
       frame_data_i[(2*l+1)*SLOT_W +: SLOT_W] & mask} : '0;
  end

endmodule

// File: rtl/i2s_mltx_lane.sv
module i2s_mltx_lane #(
  parameter int unsigned FRAME_BITS = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] load_data_i,
  output logic                  sd_o
);
  logic [FRAME_BITS-1:0] sreg;
  logic                  sd_q;

  // The bit leaving at a load is the last bit of the previous frame,
  // which gives the one-clock I2S data delay after each LRCK edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg <= '0;
      sd_q <= 1'b0;
    end else if (tick_i) begin
      sd_q <= sreg[FRAME_BITS-1];
      sreg <= load_i ? load_data_i : {sreg[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign sd_o = sd_q;

endmodule

// File: rtl/i2s_multilane_tx.sv
module i2s_multilane_tx
  import i2s_mltx_pkg::*;
#(
  parameter int unsigned NUM_LANES  = 4,
  parameter int unsigned MCLK_HALF  = 1,
  parameter int unsigned BCLK_RATIO = 8,
  localparam int unsigned CFG_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int unsigned DATA_W    = 2 * NUM_LANES * SLOT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_valid_i,
  output logic                 frame_ready_o,
  input  logic [DATA_W-1:0]    frame_data_i,
  input  logic [CFG_W-1:0]     ch_cfg_i,
  input  logic [1:0]           wlen_i,
  output logic                 mclk_o,
  output logic                 bclk_o,
  output logic                 lrck_o,
  output logic [NUM_LANES-1:0] sd_o,
  output logic                 underrun_o
);
  localparam int unsigned FRAME_BITS = 2 * SLOT_W;

  logic                                 tick;
  logic                                 frame_start;
  logic                                 accept;
  logic                                 underrun_q;
  logic [NUM_LANES-1:0][FRAME_BITS-1:0] packed_data;

  i2s_mltx_clkgen #(
    .MCLK_HALF (MCLK_HALF),
    .BCLK_RATIO(BCLK_RATIO),
    .SLOT_W    (SLOT_W)
  ) u_clkgen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mclk_o       (mclk_o),
    .bclk_o       (bclk_o),
    .lrck_o       (lrck_o),
    .tick_o       (tick),
    .frame_start_o(frame_start)
  );

  i2s_mltx_pack #(
    .NUM_LANES(NUM_LANES)
  ) u_pack (
    .frame_data_i(frame_data_i),
    .ch_cfg_i    (ch_cfg_i),
    .wlen_i      (wlen_i),
    .lane_data_o (packed_data)
  );

  assign frame_ready_o = frame_start;
  assign accept        = frame_start && frame_valid_i;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_ser
    i2s_mltx_lane #(
      .FRAME_BITS(FRAME_BITS)
    ) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .load_i     (frame_start),
      .load_data_i(accept ? packed_data[l] : '0),
      .sd_o       (sd_o[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) underrun_q <= 1'b0;
    else if (frame_start && !frame_valid_i) underrun_q <= 1'b1;
  end

  assign underrun_o = underrun_q;

endmodule

// File: rtl/i2s_mltx_chk.sv
module i2s_mltx_chk #(
  parameter int unsigned NUM_LANES = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bclk_o,
  input logic                 lrck_o,
  input logic [NUM_LANES-1:0] sd_o,
  input logic                 frame_ready_o,
  input logic                 frame_valid_i,
  input logic                 underrun_o
);
  localparam int unsigned HALF_BITS = i2s_mltx_pkg::SLOT_W;

  logic       lrck_d;
  logic       bclk_d;
  logic       seen;
  logic [7:0] fall_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrck_d   <= 1'b1;
      bclk_d   <= 1'b0;
      seen     <= 1'b0;
      fall_cnt <= '0;
    end else begin
      lrck_d <= lrck_o;
      bclk_d <= bclk_o;
      if (lrck_o != lrck_d) begin
        seen     <= 1'b1;
        fall_cnt <= 8'd1;
      end else if (bclk_d && !bclk_o) begin
        fall_cnt <= fall_cnt + 8'd1;
      end
    end
  end

  a_r4_lrck_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrck_o) |-> $fell(bclk_o));

  a_r4_sd_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> $fell(bclk_o));

  a_r5_half_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && (lrck_o != lrck_d)) |-> (fall_cnt == 8'(HALF_BITS)));

  a_r7_ready_before_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ready_o |=> $fell(bclk_o));

  a_r8_underrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);

  a_r8_underrun_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> $past(frame_ready_o && !frame_valid_i));

endmodule

bind i2s_multilane_tx i2s_mltx_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bclk_o       (bclk_o),
  .lrck_o       (lrck_o),
  .sd_o         (sd_o),
  .frame_ready_o(frame_ready_o),
  .frame_valid_i(frame_valid_i),
  .underrun_o   (underrun_o)
);

// File: tb/test_i2s_multilane_tx.sv
module test_i2s_multilane_tx;

  typedef struct {
    logic [3:0][63:0] lane;
    string            req;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         frame_valid_i = 1'b0;
  logic         frame_ready_o;
  logic [255:0] frame_data_i = '0;
  logic [1:0]   ch_cfg_i = 2'd3;
  logic [1:0]   wlen_i = 2'd2;
  logic         mclk_o, bclk_o, lrck_o, underrun_o;
  logic [3:0]   sd_o;

  int   checks = 0;
  int   errors = 0;
  exp_t exp_q[$];

  always #2 clk_i = ~clk_i;

  i2s_multilane_tx i_i2s_multilane_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_valid_i(frame_valid_i),
    .frame_ready_o(frame_ready_o), .frame_data_i(frame_data_i),
    .ch_cfg_i(ch_cfg_i), .wlen_i(wlen_i), .mclk_o(mclk_o), .bclk_o(bclk_o),
    .lrck_o(lrck_o), .sd_o(sd_o), .underrun_o(underrun_o)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_mask(input logic [1:0] wl);
    if (wl == 2'd0) return 32'hFFFF_0000;
    if (wl == 2'd1) return 32'hFFFF_FF00;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [255:0] make_frame(input int seed);
    logic [255:0] d;
    for (int c = 0; c < 8; c++)
      d[c*32 +: 32] = (32'h9E37_79B9 * (c + 1 + seed * 8)) | 32'h0000_0101;
    return d;
  endfunction

  task automatic send_frame(input logic [255:0] d, input logic [1:0] cfg,
                            input logic [1:0] wl, input string req);
    exp_t e;
    @(negedge clk_i);
    frame_data_i  = d;
    ch_cfg_i      = cfg;
    wlen_i        = wl;
    frame_valid_i = 1'b1;
    while (!frame_ready_o) @(negedge clk_i);
    for (int l = 0; l < 4; l++) begin
      if (l <= int'(cfg))
        e.lane[l] = {d[(2*l)*32 +: 32] & ref_mask(wl), d[(2*l+1)*32 +: 32] & ref_mask(wl)};
      else
        e.lane[l] = '0;
    end
    e.req = req;
    exp_q.push_back(e);
    @(posedge clk_i);
    #1 frame_valid_i = 1'b0;
  endtask

  task automatic idle_frame(input string req);
    exp_t e;
    @(negedge clk_i);
    frame_valid_i = 1'b0;
    while (!frame_ready_o) @(negedge clk_i);
    for (int l = 0; l < 4; l++) e.lane[l] = '0;
    e.req = req;
    exp_q.push_back(e);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R8", "underrun flag after missed slot", 64'(underrun_o), 64'd1);
  endtask

  // Monitor: decodes all lanes on bclk rising edges.
  initial begin : monitor
    logic             prev_b, prev_lr, prev_m, collecting;
    logic [3:0][63:0] cap;
    int               nbits, hi_cnt, rises, cyc, last_rise, mtog;
    exp_t             e;
    prev_b = 1'b0; prev_lr = 1'b1; prev_m = 1'b0; collecting = 1'b0;
    nbits = 0; hi_cnt = 0; rises = 0; cyc = 0; last_rise = 0; mtog = 0;
    cap = '0;
    wait (rst_ni);
    forever begin
      @(negedge clk_i);
      cyc++;
      if (mclk_o != prev_m) mtog++;
      prev_m = mclk_o;
      if (bclk_o && !prev_b) begin
        rises++;
        if (rises == 2) begin
          check("R6", "system cycles per bclk period", 64'(cyc - last_rise), 64'd16);
          check("R6", "mclk toggles per bclk period", 64'(mtog), 64'd16);
        end
        last_rise = cyc;
        mtog = 0;
        if (prev_lr && !lrck_o) begin
          if (collecting) begin
            for (int l = 0; l < 4; l++) cap[l] = {cap[l][62:0], sd_o[l]};
            check("R5", "lrck high bit clocks per frame", 64'(hi_cnt), 64'd32);
            if (exp_q.size() == 0) begin
              check("R7", "frame with no expected entry", 64'd1, 64'd0);
            end else begin
              e = exp_q.pop_front();
              for (int l = 0; l < 4; l++)
                check(e.req, $sformatf("lane %0d stream", l), cap[l], e.lane[l]);
            end
          end
          collecting = 1'b1;
          nbits = 0;
          hi_cnt = 0;
        end else if (collecting) begin
          for (int l = 0; l < 4; l++) cap[l] = {cap[l][62:0], sd_o[l]};
          nbits++;
          if (lrck_o) hi_cnt++;
        end
        prev_lr = lrck_o;
      end
      prev_b = bclk_o;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    logic [255:0] ones;
    ones = '1;
    repeat (5) @(negedge clk_i);
    // R9: reset state
    check("R9", "bclk in reset", 64'(bclk_o), 64'd0);
    check("R9", "mclk in reset", 64'(mclk_o), 64'd0);
    check("R9", "lrck in reset", 64'(lrck_o), 64'd1);
    check("R9", "sd in reset", 64'(sd_o), 64'd0);
    check("R9", "ready in reset", 64'(frame_ready_o), 64'd0);
    check("R9", "underrun in reset", 64'(underrun_o), 64'd0);
    rst_ni = 1'b1;

    send_frame(make_frame(1), 2'd3, 2'd2, "R1 R5 8ch/32b");
    send_frame(make_frame(2), 2'd0, 2'd0, "R2 R3 2ch/16b");
    send_frame(make_frame(3), 2'd1, 2'd1, "R2 R3 4ch/24b");
    send_frame(make_frame(4), 2'd2, 2'd3, "R2 R3 6ch/32b");
    send_frame(ones,          2'd3, 2'd0, "R3 16b padding");
    @(negedge clk_i);
    check("R8", "no underrun while fed", 64'(underrun_o), 64'd0);
    idle_frame("R8 silent frame");
    send_frame(make_frame(5), 2'd3, 2'd1, "R7 after underrun");
    @(negedge clk_i);
    check("R8", "underrun stays set", 64'(underrun_o), 64'd1);
    idle_frame("R8 trailing silence");
    idle_frame("R8 flush");
    repeat (1200) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule